// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table index puts the most recent bits of a global taken/not-taken history register above a group of low branch-address bits. The address bits are taken after a configurable number of always-zero low bits is skipped. That number is 2 for fixed 4-byte instructions and 0 for byte-aligned code.

Each request carries the branch address and its resolved outcome. The block then does four things for that branch. It reads the selected counter and predicts taken when the value is 2 or more. It flags a mispredict when the guess disagrees with the outcome. It moves the counter one step toward the outcome, without wrapping. Finally it shifts the outcome into the history register.

Two saturating counters track the number of branches accepted and the number mispredicted, so the block can be used to measure prediction quality. After reset, a sweep writes zero into every counter and clears the history. During the sweep a busy flag is high and requests are dropped.

Top module: `gbp_predictor`

## Requirements
- R1: After synchronous reset is released, `busy` stays high for exactly 2^(HIST_W+AIW) clock cycles and then falls. A request presented while `busy` is high is dropped: it produces no response and changes no count.
- R2: The table index is {history[HIST_W-1:0], req_addr[LO_DROP +: AIW]}. Addresses that differ only below bit LO_DROP, or only above bit LO_DROP+AIW-1, share a counter when the history is the same.
- R3: The prediction is taken exactly when the selected counter value is 2 or 3. Just after the reset sweep every counter is 0, so the first branch at each index is predicted not-taken.
- R4: `resp_mispredict` is 1 exactly when `resp_pred_taken` differs from the resolved outcome of that request.
- R5: A taken outcome raises the selected counter by one, stopping at 3. A not-taken outcome lowers it by one, stopping at 0.
- R6: After each accepted request, the history shifts left by one and the outcome enters bit 0. Both the index and the prediction use the history and counter values from before the current branch. This holds for back-to-back requests that hit the same counter.
- R7: A request accepted at clock edge T produces `resp_valid` = 1, together with its prediction and mispredict flag, after edge T+1. `resp_valid` is 0 in every other cycle.
- R8: `branch_count` rises by one for every accepted request. `mispredict_count` rises by one for every accepted request that mispredicts. Both update after edge T+1 and both hold at 2^CNT_W-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the table sweep |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Address of the branch |
| req_taken | input | 1 | Resolved outcome, 1 = taken |
| busy | output | 1 | Table sweep in progress; requests are dropped |
| resp_valid | output | 1 | Response for the request accepted one edge earlier |
| resp_pred_taken | output | 1 | Predicted direction |
| resp_mispredict | output | 1 | Prediction differed from the outcome |
| branch_count | output | CNT_W | Saturating count of accepted requests |
| mispredict_count | output | CNT_W | Saturating count of mispredicted requests |

## Verification
The assertions assume that reset is held for at least two clock cycles and that `req_valid` and `req_taken` never carry unknown values. With these assumptions, the two-cycle look-back from a response to its request always lands on sampled reset-time or request values. The bench holds reset for several cycles and drives every input to a known value on every cycle. This includes the sweep period, during which it deliberately keeps `req_valid` high.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t CTR_MIN = 2'd0;

  function automatic logic ctr_predicts_taken(ctr_t c);
    return c[1];
  endfunction

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int HIST_W  = 5,
  parameter int AIW     = 6,
  parameter int ADDR_W  = 32,
  parameter int LO_DROP = 2,
  localparam int IDX_W  = HIST_W + AIW
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  always_comb idx = {hist, addr[LO_DROP +: AIW]};
endmodule

// File: rtl/gbp_table.sv
module gbp_table import gbp_pkg::*; #(
  parameter int IDX_W  = 11,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_data
);
  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/gbp_sat_cnt.sv
module gbp_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != '1) count <= count + 1'b1;
  end
endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor import gbp_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 5,
  parameter int AIW     = 6,
  parameter int LO_DROP = 2,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_taken,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_pred_taken,
  output logic              resp_mispredict,
  output logic [CNT_W-1:0]  branch_count,
  output logic [CNT_W-1:0]  mispredict_count
);
  localparam int IDX_W = HIST_W + AIW;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic              clr_active;
  logic [IDX_W-1:0]  clr_ptr;
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  req_idx;
  logic              accept;

  logic              s1_valid, s1_taken;
  logic [IDX_W-1:0]  s1_idx;
  ctr_t              rd_data;

  logic              wb_valid;
  logic [IDX_W-1:0]  wb_idx;
  ctr_t              wb_val;

  ctr_t              cur_ctr, new_ctr;
  logic              s1_pred, s1_mis;

  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_widx;
  ctr_t              tbl_wdata;

  assign busy   = clr_active;
  assign accept = req_valid && !clr_active;

  gbp_index #(.HIST_W(HIST_W), .AIW(AIW), .ADDR_W(ADDR_W), .LO_DROP(LO_DROP)) index_i (
    .hist(hist), .addr(req_addr), .idx(req_idx)
  );

  // Reset sweep and global history
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_active <= 1'b1;
      clr_ptr    <= '0;
      hist       <= '0;
    end else begin
      if (clr_active) begin
        clr_ptr <= clr_ptr + 1'b1;
        if (clr_ptr == LAST_IDX) clr_active <= 1'b0;
      end
      if (accept) hist <= (hist << 1) | HIST_W'(req_taken);
    end
  end

  // Stage 1 capture: request fields alongside the synchronous table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_taken <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_taken <= req_taken;
        s1_idx   <= req_idx;
      end
    end
  end

  // Forward the counter written one edge earlier; the table returns old data then
  always_comb begin
    cur_ctr = (wb_valid && wb_idx == s1_idx) ? wb_val : rd_data;
    new_ctr = ctr_step(cur_ctr, s1_taken);
    s1_pred = ctr_predicts_taken(cur_ctr);
    s1_mis  = s1_pred ^ s1_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_val   <= CTR_MIN;
    end else begin
      wb_valid <= s1_valid;
      wb_idx   <= s1_idx;
      wb_val   <= new_ctr;
    end
  end

  always_comb begin
    tbl_we    = clr_active || s1_valid;
    tbl_widx  = clr_active ? clr_ptr : s1_idx;
    tbl_wdata = clr_active ? CTR_MIN : new_ctr;
  end

  gbp_table #(.IDX_W(IDX_W)) table_i (
    .clk(clk), .rd_en(accept), .rd_idx(req_idx), .rd_data(rd_data),
    .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_data(tbl_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid      <= 1'b0;
      resp_pred_taken <= 1'b0;
      resp_mispredict <= 1'b0;
    end else begin
      resp_valid <= s1_valid;
      if (s1_valid) begin
        resp_pred_taken <= s1_pred;
        resp_mispredict <= s1_mis;
      end
    end
  end

  gbp_sat_cnt #(.W(CNT_W)) br_cnt_i (
    .clk(clk), .rst(rst), .inc(s1_valid), .count(branch_count)
  );
  gbp_sat_cnt #(.W(CNT_W)) mis_cnt_i (
    .clk(clk), .rst(rst), .inc(s1_valid && s1_mis), .count(mispredict_count)
  );
endmodule

// File: rtl/gbp_chk.sv
module gbp_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_taken,
  input logic             busy,
  input logic             resp_valid,
  input logic             resp_pred_taken,
  input logic             resp_mispredict,
  input logic [CNT_W-1:0] branch_count,
  input logic [CNT_W-1:0] mispredict_count
);
  // R7
  resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid == $past(req_valid && !busy, 2));

  // R4
  mispredict_flag_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_mispredict == (resp_pred_taken != $past(req_taken, 2))));

  // R8
  branch_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid && !busy, 2) && $past(branch_count) != '1)
      |-> branch_count == $past(branch_count) + 1'b1);

  // R8
  count_order_chk: assert property (@(posedge clk) disable iff (rst)
    mispredict_count <= branch_count);

  // R1
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy, 2) |-> !resp_valid);
endmodule

bind gbp_predictor gbp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_taken(req_taken),
  .busy(busy), .resp_valid(resp_valid), .resp_pred_taken(resp_pred_taken),
  .resp_mispredict(resp_mispredict), .branch_count(branch_count),
  .mispredict_count(mispredict_count)
);

// File: tb/gbp_predictor_tb.sv
module gbp_predictor_tb_top;
  localparam int HIST_W = 5, AIW = 6, LO_DROP = 2;
  localparam int DEPTH = 1 << (HIST_W + AIW);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_taken = 1'b0;
  logic [31:0] req_addr = '0;
  logic busy, resp_valid, resp_pred, resp_mis;
  logic [31:0] bcnt, mcnt;

  gbp_predictor #(.HIST_W(HIST_W), .AIW(AIW), .LO_DROP(LO_DROP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_taken(req_taken), .busy(busy), .resp_valid(resp_valid),
    .resp_pred_taken(resp_pred), .resp_mispredict(resp_mis),
    .branch_count(bcnt), .mispredict_count(mcnt)
  );

  // Small instance for counter saturation: 4 table entries, 4-bit counts
  logic s_valid = 1'b0, s_taken = 1'b0;
  logic [31:0] s_addr = '0;
  logic s_busy, s_rvalid, s_pred, s_mis;
  logic [3:0] s_bcnt, s_mcnt;

  gbp_predictor #(.HIST_W(1), .AIW(1), .LO_DROP(0), .CNT_W(4)) sat_i (
    .clk(clk), .rst(rst), .req_valid(s_valid), .req_addr(s_addr),
    .req_taken(s_taken), .busy(s_busy), .resp_valid(s_rvalid),
    .resp_pred_taken(s_pred), .resp_mispredict(s_mis),
    .branch_count(s_bcnt), .mispredict_count(s_mcnt)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model
  int unsigned model [DEPTH];
  int unsigned m_hist = 0;
  longint exp_b = 0, exp_m = 0;

  typedef struct { bit v; bit pred; bit mis; longint b; longint m; } exp_t;
  exp_t pipe0, pipe1;

  function automatic int unsigned idx_of(logic [31:0] a, int unsigned h);
    return ((h & ((1 << HIST_W) - 1)) << AIW) | ((a >> LO_DROP) & ((1 << AIW) - 1));
  endfunction

  function automatic exp_t model_step(bit v, logic [31:0] a, bit t);
    exp_t e;
    e.v = v; e.pred = 0; e.mis = 0;
    if (v) begin
      int unsigned i = idx_of(a, m_hist);
      e.pred = model[i] >= 2;
      e.mis = e.pred != t;
      if (t && model[i] < 3) model[i]++;
      else if (!t && model[i] > 0) model[i]--;
      m_hist = ((m_hist << 1) | t) & ((1 << HIST_W) - 1);
      exp_b++;
      if (e.mis) exp_m++;
    end
    e.b = exp_b; e.m = exp_m;
    return e;
  endfunction

  // One negedge step: check the response of the request driven two negedges ago, then drive
  task automatic step(bit v, logic [31:0] a, bit t);
    @(negedge clk);
    chk(resp_valid == pipe1.v, "R7", "resp_valid", resp_valid, pipe1.v);
    if (pipe1.v) begin
      chk(resp_pred == pipe1.pred, "R2 R3 R5 R6", "prediction", resp_pred, pipe1.pred);
      chk(resp_mis == pipe1.mis, "R4", "mispredict", resp_mis, pipe1.mis);
    end
    chk(bcnt == pipe1.b, "R8", "branch_count", bcnt, pipe1.b);
    chk(mcnt == pipe1.m, "R8", "mispredict_count", mcnt, pipe1.m);
    pipe1 = pipe0;
    req_valid = v; req_addr = a; req_taken = t;
    pipe0 = model_step(v, a, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] pool [8];
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    pipe0 = '{0, 0, 0, 0, 0};
    pipe1 = '{0, 0, 0, 0, 0};
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) pool[i] = $urandom & 32'h0000_0ffc;
    pool[1] = pool[0] | 32'h3;           // R2: differs only below LO_DROP
    pool[2] = pool[0] ^ 32'h0010_0000;   // R2: differs only above the index field

    repeat (5) @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b1; req_taken = 1'b1; req_addr = 32'h40;
    chk(busy == 1'b1, "R1", "busy at release", busy, 1);
    n = 0;
    while (busy && n < DEPTH + 10) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    // R1: sweep length and dropped requests
    chk(n == DEPTH, "R1", "busy cycles", n, DEPTH);
    chk(resp_valid == 1'b0, "R1", "resp_valid after busy requests", resp_valid, 0);
    chk(bcnt == 0, "R1", "branch_count after busy requests", bcnt, 0);
    chk(mcnt == 0, "R1", "mispredict_count at reset", mcnt, 0);
    chk(s_busy == 1'b0, "R1", "small instance sweep done", s_busy, 0);

    // Directed: fresh counter predicts not-taken (R3), then saturation up and down (R5)
    for (int i = 0; i < 6; i++) step(1, pool[0], 1);
    for (int i = 0; i < 6; i++) step(1, pool[0], 0);
    // Back-to-back same entry with alternating outcomes (R6)
    for (int i = 0; i < 8; i++) step(1, pool[3], i[0]);
    // Aliasing addresses R2
    for (int i = 0; i < 9; i++) step(1, pool[i % 3], 1);
    step(0, 0, 0); step(0, 0, 0);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      int unsigned k = $urandom % 8;
      bit v = ($urandom % 5) != 0;
      bit t = (k < 4) ? (($urandom % 8) != 0) : (($urandom % 2) == 1);
      step(v, pool[k], t);
    end
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);

    // R8 saturation on the 4-bit instance: drive the outcome opposite to its prediction
    begin
      int unsigned sm [4];
      int unsigned sh = 0;
      for (int i = 0; i < 4; i++) sm[i] = 0;
      for (int i = 0; i < 20; i++) begin
        int unsigned si;
        bit sp;
        @(negedge clk);
        si = ((sh & 1) << 1) | 1;
        sp = sm[si] >= 2;
        s_valid = 1'b1; s_addr = 32'h1; s_taken = !sp;
        if (!sp && sm[si] < 3) sm[si]++;
        else if (sp && sm[si] > 0) sm[si]--;
        sh = !sp;
      end
      @(negedge clk);
      s_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(s_bcnt == 4'hf, "R8", "saturated branch_count", s_bcnt, 15);
      chk(s_mcnt == 4'hf, "R8", "saturated mispredict_count", s_mcnt, 15);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule